// File: doc/BRIEF.md
# Chopped Third-Order Sinc Decimator

This block turns a one-bit sigma-delta bitstream into signed conversion words. The analog front end is chopped: its inputs are reversed on every other conversion. The block drives that reversal through `chop_phase`. Each incoming bit is XOR-ed with the current phase and mapped to +1 or -1. The demodulated stream then passes through a third-order sinc filter, built as three integrators that run at the modulator rate and three differencers that run at the decimated rate. The decimation ratio is 8 times a programmable factor `SF`.

A chopped front end leaves an offset that flips sign from one conversion to the next. To cancel it, each new filter output is averaged with the one before it. The average is clamped to a 24-bit signed word and written to the output register. A one-cycle `drdy` pulse marks each write. After reset, and after every write of `SF`, the first three decimation periods produce no output, because the differencer history and the averaging partner are still being refilled.

The bitstream side has no back-pressure. The modulator is free-running, so `mod_en` qualifies each sample and there is no ready signal. The output side also has no back-pressure. `dout` holds its value until the next valid result, so a consumer has a full decimation period to take each word after `drdy`.

Top module: `chop_sinc3_decim`

## Requirements
- R1: While `rst_n` is low and after it is released, `dout` is 0, `drdy` is 0, `chop_phase` is 0 and the factor SF is 1.
- R2: A cycle with `sf_wr` high loads `sf_in` as SF, and a value of 0 is stored as 1. It clears the integrators, differencers, sample count and averaging partner, and sets `chop_phase` to 0. A sample offered in that same cycle is discarded. The ratio R = 8·SF counts only cycles with `mod_en` high.
- R3: Each accepted sample is demodulated to d = +1 when `mod_bit` XOR `chop_phase` is 1, and to d = -1 otherwise.
- R4: Number the accepted samples n = 0, 1, … from the last restart. The k-th filter output (k ≥ 1) uses samples up to n = kR-1. It equals the sum over j of h[j]·d[n-j], where h is three length-R boxes convolved together and samples before the restart count as 0.
- R5: `chop_phase` toggles on the clock edge that accepts the last sample of each decimation period, and at no other time apart from reset and SF writes.
- R6: The word written is floor((y_k + y_(k-1)) / 2) of the two most recent filter outputs.
- R7: An average above 8388607 is written as 8388607, and an average below -8388608 is written as -8388608.
- R8: After a restart, the periods k = 1, 2 and 3 produce no `drdy`. The first `drdy` follows period k = 4, and one follows every period after that.
- R9: `drdy` is high for exactly the one cycle after the edge that accepts the period's last sample. `dout` changes only in that cycle and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_wr | input | 1 | Write strobe for the decimation factor |
| sf_in | input | SF_W | New decimation factor |
| mod_en | input | 1 | Modulator sample qualifier |
| mod_bit | input | 1 | Modulator comparator bit |
| chop_phase | output | 1 | Input reversal phase for the front end |
| dout | output | DOUT_W | Averaged, saturated conversion word |
| drdy | output | 1 | One-cycle pulse when `dout` is written |

## Verification
The timing under test is the edge that accepts the last enabled sample of a period. After that edge, `chop_phase` has toggled, and `drdy` with a new `dout` must be visible in the same cycle, one register stage from the sample. The bench drives inputs on the falling edge and checks at the following falling edge. At every period boundary it checks the phase, the strobe, and the value computed from a direct triple-box convolution of its own demodulated history. It also checks that no strobe appears in any other cycle. Restart checks come in the cycle right after an SF write, and saturation is exercised with SF = 26, where the filter gain 208³ exceeds the 24-bit range.

// File: rtl/cs3_pkg.sv
package cs3_pkg;
  localparam int unsigned ORDER = 3;

  function automatic logic signed [1:0] to_pm1(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction
endpackage

// File: rtl/cs3_ctrl.sv
module cs3_ctrl #(
  parameter int unsigned SF_W = 8,
  localparam int unsigned CNT_W = SF_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sf_wr,
  input  logic [SF_W-1:0] sf_in,
  input  logic            mod_en,
  output logic            restart,
  output logic            sample_en,
  output logic            frame_end,
  output logic            out_ok,
  output logic            chop_phase
);
  logic [SF_W-1:0]  sf_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic [1:0]       settle_q;

  assign last_idx  = {sf_q, 3'b000} - CNT_W'(1);
  assign restart   = sf_wr;
  assign sample_en = mod_en && !sf_wr;
  assign frame_end = sample_en && (cnt_q == last_idx);
  assign out_ok    = frame_end && (settle_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_q       <= SF_W'(1);
      cnt_q      <= '0;
      settle_q   <= '0;
      chop_phase <= 1'b0;
    end else if (sf_wr) begin
      sf_q       <= (sf_in == '0) ? SF_W'(1) : sf_in;
      cnt_q      <= '0;
      settle_q   <= '0;
      chop_phase <= 1'b0;
    end else if (frame_end) begin
      cnt_q      <= '0;
      chop_phase <= !chop_phase;
      if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end else if (sample_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  p_sf_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sf_q != '0);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx);
  p_chop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chop_phase) |-> $past(frame_end || sf_wr));
endmodule

// File: rtl/cs3_integ.sv
module cs3_integ
  import cs3_pkg::*;
#(
  parameter int unsigned ACC_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [1:0]       din,
  output logic signed [ACC_W-1:0] acc_next
);
  logic signed [ACC_W-1:0] acc_q [ORDER];
  logic signed [ACC_W-1:0] nxt   [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign nxt[s] = acc_q[s] + {{(ACC_W-2){din[1]}}, din};
    end else begin : g_tail
      assign nxt[s] = acc_q[s] + nxt[s-1];
    end
  end

  assign acc_next = nxt[ORDER-1];

  always_ff @(posedge clk) begin
    for (int s = 0; s < ORDER; s++) begin
      if (!rst_n || clr) acc_q[s] <= '0;
      else if (en)       acc_q[s] <= nxt[s];
    end
  end
endmodule

// File: rtl/cs3_comb.sv
module cs3_comb
  import cs3_pkg::*;
#(
  parameter int unsigned ACC_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] dly_q [ORDER];
  logic signed [ACC_W-1:0] stg   [ORDER+1];

  assign stg[0] = din;
  for (genvar s = 0; s < ORDER; s++) begin : g_diff
    assign stg[s+1] = stg[s] - dly_q[s];
  end
  assign dout = stg[ORDER];

  always_ff @(posedge clk) begin
    for (int s = 0; s < ORDER; s++) begin
      if (!rst_n || clr) dly_q[s] <= '0;
      else if (en)       dly_q[s] <= stg[s];
    end
  end
endmodule

// File: rtl/chop_sinc3_decim.sv
module chop_sinc3_decim
  import cs3_pkg::*;
#(
  parameter int unsigned SF_W   = 8,
  parameter int unsigned DOUT_W = 24,
  localparam int unsigned R_MAX = 8 * ((1 << SF_W) - 1),
  localparam int unsigned ACC_W = 1 + ORDER * $clog2(R_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_wr,
  input  logic [SF_W-1:0]   sf_in,
  input  logic              mod_en,
  input  logic              mod_bit,
  output logic              chop_phase,
  output logic [DOUT_W-1:0] dout,
  output logic              drdy
);
  logic restart, sample_en, frame_end, out_ok;
  logic signed [1:0]       d_pm;
  logic signed [ACC_W-1:0] integ_v, y_new, y_q, avg;
  logic signed [ACC_W:0]   pair_sum;
  logic [DOUT_W-1:0]       word;

  cs3_ctrl #(.SF_W(SF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sf_wr(sf_wr), .sf_in(sf_in), .mod_en(mod_en),
    .restart(restart), .sample_en(sample_en), .frame_end(frame_end),
    .out_ok(out_ok), .chop_phase(chop_phase)
  );

  assign d_pm = to_pm1(mod_bit ^ chop_phase);

  cs3_integ #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(sample_en),
    .din(d_pm), .acc_next(integ_v)
  );

  cs3_comb #(.ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(frame_end),
    .din(integ_v), .dout(y_new)
  );

  // Pair the new filter output with the previous one; dropping the LSB of
  // the two's-complement sum is a floor division by two.
  assign pair_sum = {y_new[ACC_W-1], y_new} + {y_q[ACC_W-1], y_q};
  assign avg      = pair_sum[ACC_W:1];

  if (ACC_W > DOUT_W) begin : g_sat
    logic hi_same;
    assign hi_same = (avg[ACC_W-1:DOUT_W-1] == '0) ||
                     (avg[ACC_W-1:DOUT_W-1] == '1);
    always_comb begin
      if (hi_same)           word = avg[DOUT_W-1:0];
      else if (avg[ACC_W-1]) word = {1'b1, {(DOUT_W-1){1'b0}}};
      else                   word = {1'b0, {(DOUT_W-1){1'b1}}};
    end
  end else begin : g_ext
    assign word = DOUT_W'(avg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q  <= '0;
      dout <= '0;
      drdy <= 1'b0;
    end else begin
      drdy <= out_ok;
      if (restart)        y_q <= '0;
      else if (frame_end) y_q <= y_new;
      if (out_ok) dout <= word;
    end
  end

  p_drdy_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drdy |=> !drdy);
  p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy |-> $stable(dout));
  p_no_drdy_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sf_wr) |-> !drdy);
  p_chop_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sf_wr) |-> !chop_phase);
endmodule

// File: tb/chop_sinc3_decim_tb_top.sv
module chop_sinc3_decim_tb_top;
  localparam int SF_W = 8;
  localparam int DOUT_W = 24;
  localparam longint SAT_HI = 64'sd8388607;
  localparam longint SAT_LO = -64'sd8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sf_wr = 1'b0;
  logic [SF_W-1:0] sf_in = '0;
  logic mod_en = 1'b0;
  logic mod_bit = 1'b0;
  logic chop_phase;
  logic [DOUT_W-1:0] dout;
  logic drdy;

  always #4 clk = !clk;

  chop_sinc3_decim #(.SF_W(SF_W), .DOUT_W(DOUT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sf_wr(sf_wr), .sf_in(sf_in),
    .mod_en(mod_en), .mod_bit(mod_bit), .chop_phase(chop_phase),
    .dout(dout), .drdy(drdy)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int hist [1024];
  longint h [1024];
  int n_smp, k_frm, rlen;
  longint y_prev;
  bit exp_chop;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void build_h(input int r);
    longint t [1024];
    for (int i = 0; i < 1024; i++) begin t[i] = 0; h[i] = 0; end
    for (int i = 0; i <= 2*r-2; i++) t[i] = r - ((i > r-1) ? i-(r-1) : (r-1)-i);
    for (int j = 0; j <= 3*r-3; j++)
      for (int i = ((j-r+1) > 0 ? j-r+1 : 0); i <= ((j < 2*r-2) ? j : 2*r-2); i++)
        h[j] += t[i];
  endfunction

  function automatic longint calc_y();
    longint acc = 0;
    for (int j = 0; j <= 3*rlen-3; j++) begin
      int idx = n_smp - 1 - j;
      if (idx >= 0) acc += h[j] * longint'(hist[idx % 1024]);
    end
    return acc;
  endfunction

  function automatic longint sat24(input longint v);
    if (v > SAT_HI) return SAT_HI;
    if (v < SAT_LO) return SAT_LO;
    return v;
  endfunction

  task automatic model_restart(input int sf);
    rlen = 8 * ((sf == 0) ? 1 : sf);
    n_smp = 0; k_frm = 0; y_prev = 0; exp_chop = 1'b0;
    build_h(rlen);
  endtask

  // one cycle: dv is the demodulated sample wanted (1 -> +1)
  task automatic step(input bit en, input bit dv);
    mod_en = en;
    mod_bit = dv ^ chop_phase;
    @(negedge clk);
    if (en) begin
      hist[n_smp % 1024] = dv ? 1 : -1;
      n_smp++;
      if (n_smp % rlen == 0) begin
        longint y, e;
        k_frm++;
        y = calc_y();
        exp_chop = !exp_chop;
        chk(chop_phase == exp_chop, "R5 chop toggle", longint'(chop_phase), longint'(exp_chop));
        if (k_frm >= 4) begin
          e = sat24((y + y_prev) >>> 1);
          chk(drdy == 1'b1, "R8 R9 drdy at boundary", longint'(drdy), 1);
          chk(longint'($signed(dout)) == e, "R3 R4 R6 R7 dout",
              longint'($signed(dout)), e);
        end else begin
          chk(drdy == 1'b0, "R8 no drdy while settling", longint'(drdy), 0);
        end
        y_prev = y;
      end else if (drdy) chk(1'b0, "R9 stray drdy", 1, 0);
    end else if (drdy) chk(1'b0, "R9 stray drdy", 1, 0);
  endtask

  task automatic write_sf(input int sf);
    sf_wr = 1'b1;
    sf_in = SF_W'(sf);
    mod_en = 1'b1;
    mod_bit = 1'b1;
    @(negedge clk);
    sf_wr = 1'b0;
    model_restart(sf);
    chk(chop_phase == 1'b0, "R2 chop cleared by write", longint'(chop_phase), 0);
    chk(drdy == 1'b0, "R8 no drdy after write", longint'(drdy), 0);
  endtask

  task automatic run_frames(input int frames, input int mode, input int en_pct);
    int target = n_smp + frames * rlen;
    while (n_smp < target) begin
      bit en = ($urandom % 100) < en_pct;
      bit dv = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : 1'($urandom);
      step(en, dv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(dout == '0, "R1 dout in reset", longint'(dout), 0);
    chk(drdy == 1'b0, "R1 drdy in reset", longint'(drdy), 0);
    chk(chop_phase == 1'b0, "R1 chop in reset", longint'(chop_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == '0 && drdy == 1'b0, "R1 idle after reset", longint'(dout), 0);
    model_restart(1);              // default factor 1
    run_frames(7, 0, 100);         // constant +1: steady 512
    run_frames(10, 2, 60);         // random bits, random gaps
    write_sf(0);                   // 0 behaves as 1
    run_frames(8, 2, 100);
    write_sf(3);
    run_frames(9, 2, 50);
    write_sf(2);
    run_frames(2, 2, 80);
    write_sf(4);                   // restart mid-settle
    run_frames(8, 2, 70);
    write_sf(26);                  // gain above 24-bit range
    run_frames(6, 0, 100);
    write_sf(26);
    run_frames(6, 1, 100);
    write_sf(5);
    run_frames(8, 2, 90);
    repeat (4) step(1'b0, 1'b0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule